// File: doc/BRIEF.md
# Stream Backpressure Stall Watchdog

This block watches one channel of a streaming DMA engine for a stalled sink. The engine still has data to deliver, but the downstream consumer keeps its ready line low. When the stall lasts longer than a programmed interval, the block emits a one-cycle stall-timeout pulse. The interrupt logic of the channel records that pulse as its stream-timeout status.

The interval comes from a two-stage timer. A 12-bit prescaler divides the clock by (prescale + 1) to make a slow tick. A 12-bit timeout count then counts those ticks down.
- The timer starts from fresh values whenever a stall begins.
- It stops as soon as the stall ends or a transfer handshake completes.
- It is one-shot: after it has fired, it stays quiet until the stall ends and a new stall begins.
- A separate enable input gates the whole watchdog.

Top module: `bpw_stall_watchdog`

## Requirements
- R1: While reset is asserted and directly after it, `stall_timeout` is 0.
- R2: The timer starts only in a cycle where `cfg_enable`=1, `data_pending`=1, `sink_ready`=0 and `xfer_fire`=0. In that cycle it loads the prescaler with `cfg_prediv` and the tick counter with `cfg_limit`. If any one of these conditions is missing, no pulse is ever produced.
- R3: Number the first clock edge that samples a stall as edge 1. Ticks occur at edges 1+n*(`cfg_prediv`+1). The pulse is high in the cycle after edge 1+max(`cfg_limit`,1)*(`cfg_prediv`+1).
- R4: A `cfg_limit` of 0 or 1 fires on the first prescaled tick after arming. This holds for every prescale value, including 0 (tick every cycle) and the largest value 0xFFF.
- R5: `stall_timeout` is high for exactly one clock cycle per expiry.
- R6: The timer is one-shot. While the stall persists after a pulse, no further pulse occurs. Once the stall condition is lost for at least one cycle, a new stall re-arms it with the full interval.
- R7: `xfer_fire`=1 in any cycle stops the timer and discards its count, even if the other inputs still describe a stall. The next stall cycle re-arms with the full interval.
- R8: If `cfg_enable` or `data_pending` drops for one cycle in mid-count, the partial count is discarded. The full interval is needed again after the condition returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Watchdog enable; 0 keeps the timer idle and suppresses expiry |
| cfg_prediv | input | 12 | Prescale value; tick every cfg_prediv+1 cycles |
| cfg_limit | input | 12 | Timeout value in ticks, captured at arming |
| data_pending | input | 1 | Channel still has bytes left to transfer |
| sink_ready | input | 1 | Stream sink can accept data |
| xfer_fire | input | 1 | A stream handshake completed this cycle |
| stall_timeout | output | 1 | One-cycle stream-timeout pulse |

## Verification
Two situations are hardest to reach from the ports:
- **One-shot behaviour.** The bench must hold the stall well past an expiry and count pulses. It then releases the stall for exactly one cycle and stalls again, which shows that the re-arm gives a fresh full interval.
- **Mid-count restarts.** A restart shows only as timing, so each restart test runs partway into a count and injects a single-cycle handshake, enable drop or pending drop. It then measures the edge at which the pulse appears, counted from the restart, against the closed-form edge number.

The largest prescale is reached by pairing it with a limit of 1, which keeps the run to about four thousand cycles.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
    localparam int PREDIV_W = 12;
    localparam int LIMIT_W  = 12;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_SPENT = 2'd2
    } wd_state_e;

    typedef struct packed {
        wd_state_e state;
        logic      pulse;
    } ctrl_regs_t;
endpackage

// File: rtl/bpw_prescaler.sv
module bpw_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (load) begin
            st_d.cnt = div;
        end else if (run) begin
            if (st_q.cnt == '0) begin
                tick     = 1'b1;
                st_d.cnt = div;   // divider is re-read at every tick
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bpw_countdown.sv
module bpw_countdown #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cd_regs_t;

    cd_regs_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = tick && (st_q.cnt <= W'(1));
        if (load) begin
            st_d.cnt = limit;
        end else if (tick && !expire) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bpw_arm_ctrl.sv
module bpw_arm_ctrl
    import bpw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stall_cond,
    input  logic      progress,
    input  logic      expire,
    output logic      load,
    output logic      run,
    output logic      pulse,
    output wd_state_e state
);
    ctrl_regs_t st_d, st_q;
    logic       hold;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        load       = 1'b0;
        run        = 1'b0;
        hold       = stall_cond && !progress;
        unique case (st_q.state)
            WD_IDLE: begin
                if (hold) begin
                    load       = 1'b1;
                    st_d.state = WD_RUN;
                end
            end
            WD_RUN: begin
                if (!hold) begin
                    st_d.state = WD_IDLE;
                end else begin
                    run = 1'b1;
                    if (expire) begin
                        st_d.state = WD_SPENT;
                        st_d.pulse = 1'b1;
                    end
                end
            end
            WD_SPENT: begin
                if (!hold) st_d.state = WD_IDLE;
            end
            default: st_d.state = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: WD_IDLE, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
    assign state = st_q.state;
endmodule

// File: rtl/bpw_stall_watchdog.sv
module bpw_stall_watchdog
    import bpw_pkg::*;
#(
    parameter int PREDIV_BITS = PREDIV_W,
    parameter int LIMIT_BITS  = LIMIT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic [PREDIV_BITS-1:0] cfg_prediv,
    input  logic [LIMIT_BITS-1:0]  cfg_limit,
    input  logic                   data_pending,
    input  logic                   sink_ready,
    input  logic                   xfer_fire,
    output logic                   stall_timeout
);
    logic      stall_cond;
    logic      tmr_load;
    logic      tmr_run;
    logic      pre_tick;
    logic      cnt_expire;
    wd_state_e ctrl_state;

    // A stall exists while bytes remain, the sink refuses them and the
    // watchdog is switched on.
    assign stall_cond = cfg_enable && data_pending && !sink_ready;

    bpw_arm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_cond (stall_cond),
        .progress   (xfer_fire),
        .expire     (cnt_expire),
        .load       (tmr_load),
        .run        (tmr_run),
        .pulse      (stall_timeout),
        .state      (ctrl_state)
    );

    bpw_prescaler #(.W(PREDIV_BITS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .div   (cfg_prediv),
        .tick  (pre_tick)
    );

    bpw_countdown #(.W(LIMIT_BITS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .tick   (pre_tick),
        .limit  (cfg_limit),
        .expire (cnt_expire)
    );
endmodule

// File: rtl/bpw_stall_watchdog_chk.sv
module bpw_stall_watchdog_chk
    import bpw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      stall_cond,
    input logic      xfer_fire,
    input logic      pre_tick,
    input wd_state_e ctrl_state,
    input logic      stall_timeout
);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_timeout |=> !stall_timeout);

    // R2
    no_stall_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_cond |=> !stall_timeout);

    // R7
    progress_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fire |=> !stall_timeout);

    // R6
    spent_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == WD_SPENT && $past(ctrl_state) == WD_SPENT) |-> !stall_timeout);

    // R3
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_timeout |-> $past(pre_tick));
endmodule

bind bpw_stall_watchdog bpw_stall_watchdog_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_cond    (stall_cond),
    .xfer_fire     (xfer_fire),
    .pre_tick      (pre_tick),
    .ctrl_state    (ctrl_state),
    .stall_timeout (stall_timeout)
);

// File: tb/tb_bpw_stall_watchdog.sv
module tb_bpw_stall_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [11:0] cfg_prediv = '0;
    logic [11:0] cfg_limit = '0;
    logic        data_pending = 1'b0;
    logic        sink_ready = 1'b1;
    logic        xfer_fire = 1'b0;
    logic        stall_timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpw_stall_watchdog dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_prediv    (cfg_prediv),
        .cfg_limit     (cfg_limit),
        .data_pending  (data_pending),
        .sink_ready    (sink_ready),
        .xfer_fire     (xfer_fire),
        .stall_timeout (stall_timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_edge(input int p, input int t);
        int k = (t < 1) ? 1 : t;
        return 1 + k * (p + 1);
    endfunction

    // Count edges from the next one; report first edge after which the pulse is seen.
    task automatic watch(input int edges, output int first, output int highs);
        first = 0;
        highs = 0;
        for (int n = 1; n <= edges; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (stall_timeout) begin
                highs++;
                if (first == 0) first = n;
            end
        end
    endtask

    task automatic go_quiet();
        @(negedge clk);
        data_pending = 1'b0;
        sink_ready   = 1'b1;
        xfer_fire    = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stall(input logic [11:0] p, input logic [11:0] t);
        cfg_enable   = 1'b1;
        cfg_prediv   = p;
        cfg_limit    = t;
        data_pending = 1'b1;
        sink_ready   = 1'b0;
        xfer_fire    = 1'b0;
    endtask

    task automatic t_reset();
        check(stall_timeout == 1'b0, "R1 during reset", int'(stall_timeout), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stall_timeout == 1'b0, "R1 after reset", int'(stall_timeout), 0);
    endtask

    task automatic t_basic();
        int first, highs;
        go_quiet();
        stall(12'd2, 12'd3);
        watch(40, first, highs);
        check(first == expect_edge(2, 3), "R3 basic expiry edge", first, expect_edge(2, 3));
        check(highs == 1, "R5 R6 single pulse while stall held", highs, 1);
        // R6: drop the stall for one cycle, then stall again
        data_pending = 1'b0;
        @(negedge clk);
        data_pending = 1'b1;
        watch(20, first, highs);
        check(first == expect_edge(2, 3), "R6 re-arm after release", first, expect_edge(2, 3));
    endtask

    task automatic t_small_limits();
        int first, highs;
        go_quiet();
        stall(12'd0, 12'd0);
        watch(10, first, highs);
        check(first == 2, "R4 limit 0 prediv 0", first, 2);
        go_quiet();
        stall(12'd3, 12'd1);
        watch(20, first, highs);
        check(first == expect_edge(3, 1), "R4 limit 1 prediv 3", first, expect_edge(3, 1));
        go_quiet();
        stall(12'd4, 12'd5);
        watch(40, first, highs);
        check(first == expect_edge(4, 5), "R3 limit 5 prediv 4", first, expect_edge(4, 5));
    endtask

    task automatic t_large_prediv();
        int first, highs;
        go_quiet();
        stall(12'hFFF, 12'd1);
        watch(4200, first, highs);
        check(first == expect_edge(4095, 1), "R4 largest prediv", first, expect_edge(4095, 1));
        check(highs == 1, "R5 largest prediv pulse count", highs, 1);
    endtask

    task automatic t_no_arm();
        int first, highs;
        go_quiet();
        stall(12'd0, 12'd2);
        cfg_enable = 1'b0;
        watch(40, first, highs);
        check(highs == 0, "R2 enable low", highs, 0);
        go_quiet();
        stall(12'd0, 12'd2);
        data_pending = 1'b0;
        watch(40, first, highs);
        check(highs == 0, "R2 nothing pending", highs, 0);
        go_quiet();
        stall(12'd0, 12'd2);
        sink_ready = 1'b1;
        watch(40, first, highs);
        check(highs == 0, "R2 sink ready", highs, 0);
    endtask

    task automatic t_progress();
        int first, highs;
        go_quiet();
        stall(12'd1, 12'd4);
        watch(6, first, highs);
        check(highs == 0, "R7 no pulse before handshake", highs, 0);
        xfer_fire = 1'b1;
        @(negedge clk);
        xfer_fire = 1'b0;
        watch(20, first, highs);
        check(first == expect_edge(1, 4), "R7 restart after handshake", first, expect_edge(1, 4));
    endtask

    task automatic t_drop_mid();
        int first, highs;
        go_quiet();
        stall(12'd1, 12'd4);
        watch(6, first, highs);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_enable = 1'b1;
        watch(20, first, highs);
        check(first == expect_edge(1, 4), "R8 restart after enable drop", first, expect_edge(1, 4));
        go_quiet();
        stall(12'd1, 12'd4);
        watch(7, first, highs);
        data_pending = 1'b0;
        @(negedge clk);
        data_pending = 1'b1;
        watch(20, first, highs);
        check(first == expect_edge(1, 4), "R8 restart after pending drop", first, expect_edge(1, 4));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_small_limits();
        t_large_prediv();
        t_no_arm();
        t_progress();
        t_drop_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule